// File: doc/BRIEF.md
# Compare and Trap Unit

This execution-stage unit decides whether a conditional-trap instruction fires. It compares a first register operand with a second operand and raises a data-exception trap when the outcome of that compare is selected by a 4-bit condition mask. The second operand can come from a register, from a 16-bit immediate in the instruction, or from a memory word that an earlier stage has already fetched. Operand width (32 or 64 bit) and signedness are chosen per instruction.

When the trap fires, the unit emits a one-cycle pulse one clock after the valid strobe. In the same cycle it presents the address of the next sequential instruction, which it keeps until the next trap. The exception subcode it reports is always zero. The unit never writes a register. Fetch, decode, the memory access and delivery of the exception are handled elsewhere.

Top module: `cmp_trap_unit`

## Requirements
- R1: While `rst` is high and after it is released, with no valid instruction seen, `trap_pulse` is 0 and `trap_addr` is 0.
- R2: `trap_pulse` rises exactly one clock after a cycle where `in_valid` is 1 and the condition holds, and lasts one cycle. A cycle with `in_valid` at 0 raises no trap in the next cycle, whatever the other inputs are.
- R3: The compare outcome is equal, low (op1 < op2) or high (op1 > op2). The trap fires when the mask bit of weight 8 is set and the outcome is equal, the bit of weight 4 is set and the outcome is low, or the bit of weight 2 is set and the outcome is high. The bit of weight 1 has no effect.
- R4: A mask whose weight-8, 4 and 2 bits are all clear (values 0 and 1) never traps.
- R5: A mask of 14 (or 15) always traps for any operands, when the source is one of the three defined sources.
- R6: With `is_signed` = 1 the operands compare as two's complement numbers. With `is_signed` = 0 they compare as unsigned numbers. For example, 1 against all-ones is low only in the unsigned form.
- R7: With `op_wide` = 0 only bits [31:0] of both operands take part in the compare. With `op_wide` = 1 all 64 bits take part.
- R8: The 16-bit immediate is sign-extended to the operand width when `is_signed` = 1 and zero-extended when `is_signed` = 0.
- R9: `src_sel` picks the second operand: 0 = `reg_b`, 1 = `imm16`, 2 = `mem_word`. The value 3 is reserved and never traps.
- R10: On a trap, `trap_addr` takes the `next_addr` of the trapping instruction and holds it until the next trap. `exc_subcode` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is present this cycle |
| src_sel | input | 2 | Second-operand source: 0 reg, 1 immediate, 2 memory, 3 reserved |
| op_wide | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| is_signed | input | 1 | 1 = signed compare, 0 = unsigned compare |
| cond_mask | input | 4 | Condition mask (8 equal, 4 low, 2 high, 1 ignored) |
| reg_a | input | 64 | First operand register value |
| reg_b | input | 64 | Second operand register value |
| imm16 | input | 16 | Immediate second operand |
| mem_word | input | 64 | Fetched memory second operand |
| next_addr | input | 64 | Address of the next sequential instruction |
| trap_pulse | output | 1 | One-cycle data-exception trap |
| trap_addr | output | 64 | Next-instruction address saved at the last trap |
| exc_subcode | output | 4 | Exception subcode, always 0 |

## Verification
The bench sweeps every mask value against every combination of source, width and signedness. Each combination is applied to a grid of operand pairs: zero, one, all-ones, the 32-bit sign boundary values, and words whose upper and lower halves differ. Pairs such as 1 against all-ones tell signed from unsigned. Pairs that agree in their low half and differ in their upper half tell a 32-bit compare from a 64-bit one. The immediate grid includes 0x8000 and 0xFFFF, so sign extension differs visibly from zero extension. Cycles with the valid strobe low and an always-trap mask check that nothing fires and that the saved address is left alone.

// File: rtl/cmptrap_pkg.sv
package cmptrap_pkg;

    localparam int unsigned WORD_W   = 64;
    localparam int unsigned NARROW_W = 32;
    localparam int unsigned IMM_W    = 16;
    localparam int unsigned MASK_W   = 4;
    localparam int unsigned SRC_W    = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_REG  = 2'd0,
        SRC_IMM  = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        CC_EQ   = 2'd0,
        CC_LOW  = 2'd1,
        CC_HIGH = 2'd2,
        CC_BAD  = 2'd3
    } cc_e;

    typedef struct packed {
        logic [WORD_W-1:0] lhs;
        logic [WORD_W-1:0] rhs;
        logic              signed_cmp;
        logic              usable;
    } cmp_pair_t;

    // Widen a 16-bit immediate to a full word according to signedness.
    function automatic logic [WORD_W-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                   input logic sgn);
        logic fill;
        fill = sgn & imm[IMM_W-1];
        return {{(WORD_W-IMM_W){fill}}, imm};
    endfunction

    // In narrow mode keep only the low half and re-extend it, so one
    // full-width comparator serves both widths.
    function automatic logic [WORD_W-1:0] fit_width(input logic [WORD_W-1:0] v,
                                                   input logic wide,
                                                   input logic sgn);
        logic fill;
        fill = sgn & v[NARROW_W-1];
        return wide ? v : {{(WORD_W-NARROW_W){fill}}, v[NARROW_W-1:0]};
    endfunction

endpackage

// File: rtl/ct_operand_sel.sv
module ct_operand_sel
    import cmptrap_pkg::*;
(
    input  src_e                 src,
    input  logic                 wide,
    input  logic                 sgn,
    input  logic [WORD_W-1:0]    reg_a,
    input  logic [WORD_W-1:0]    reg_b,
    input  logic [IMM_W-1:0]     imm,
    input  logic [WORD_W-1:0]    mem,
    output cmp_pair_t            pair
);
    logic [WORD_W-1:0] raw_rhs;
    logic              defined;

    always_comb begin
        raw_rhs = '0;
        defined = 1'b1;
        unique case (src)
            SRC_REG:  raw_rhs = reg_b;
            SRC_IMM:  raw_rhs = widen_imm(imm, sgn);
            SRC_MEM:  raw_rhs = mem;
            default:  defined = 1'b0;
        endcase
    end

    always_comb begin
        pair.lhs        = fit_width(reg_a, wide, sgn);
        pair.rhs        = fit_width(raw_rhs, wide, sgn);
        pair.signed_cmp = sgn;
        pair.usable     = defined;
    end
endmodule

// File: rtl/ct_comparator.sv
module ct_comparator
    import cmptrap_pkg::*;
(
    input  cmp_pair_t pair,
    output cc_e       code
);
    localparam int unsigned EXT_W = WORD_W + 1;

    logic signed [EXT_W-1:0] lhs_x;
    logic signed [EXT_W-1:0] rhs_x;

    // One extra bit turns both signed and unsigned compares into one signed compare.
    always_comb begin
        lhs_x = {pair.signed_cmp & pair.lhs[WORD_W-1], pair.lhs};
        rhs_x = {pair.signed_cmp & pair.rhs[WORD_W-1], pair.rhs};
        if (lhs_x == rhs_x)      code = CC_EQ;
        else if (lhs_x < rhs_x)  code = CC_LOW;
        else                     code = CC_HIGH;
    end
endmodule

// File: rtl/ct_cond_mask.sv
module ct_cond_mask
    import cmptrap_pkg::*;
(
    input  cc_e              code,
    input  logic [MASK_W-1:0] mask,
    input  logic             usable,
    output logic             hit
);
    localparam int unsigned N_OUTCOMES = MASK_W - 1;

    logic [N_OUTCOMES-1:0] outcome_sel;
    logic [N_OUTCOMES-1:0] enabled;

    // Outcome n maps to the mask bit of weight 8 >> n.
    for (genvar n = 0; n < N_OUTCOMES; n++) begin : g_outcome
        assign outcome_sel[N_OUTCOMES-1-n] = (code == cc_e'(n));
        assign enabled[N_OUTCOMES-1-n]     = mask[MASK_W-1-n];
    end

    assign hit = usable & |(outcome_sel & enabled);
endmodule

// File: rtl/cmp_trap_unit.sv
module cmp_trap_unit
    import cmptrap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned SUBCODE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SRC_W-1:0]     src_sel,
    input  logic                 op_wide,
    input  logic                 is_signed,
    input  logic [MASK_W-1:0]    cond_mask,
    input  logic [WORD_W-1:0]    reg_a,
    input  logic [WORD_W-1:0]    reg_b,
    input  logic [IMM_W-1:0]     imm16,
    input  logic [WORD_W-1:0]    mem_word,
    input  logic [ADDR_W-1:0]    next_addr,
    output logic                 trap_pulse,
    output logic [ADDR_W-1:0]    trap_addr,
    output logic [SUBCODE_W-1:0] exc_subcode
);
    cmp_pair_t pair;
    cc_e       code;
    logic      hit;
    logic      fire;

    ct_operand_sel u_sel (
        .src   (src_e'(src_sel)),
        .wide  (op_wide),
        .sgn   (is_signed),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .imm   (imm16),
        .mem   (mem_word),
        .pair  (pair)
    );

    ct_comparator u_cmp (
        .pair (pair),
        .code (code)
    );

    ct_cond_mask u_mask (
        .code   (code),
        .mask   (cond_mask),
        .usable (pair.usable),
        .hit    (hit)
    );

    assign fire = in_valid & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_pulse <= 1'b0;
            trap_addr  <= '0;
        end else begin
            trap_pulse <= fire;
            if (fire) trap_addr <= next_addr;
        end
    end

    assign exc_subcode = '0;

    // R2: an idle cycle never leads to a trap
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !trap_pulse);

    // R10: a trap presents the address given with the trapping instruction
    p_addr_capture_r10: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> trap_addr == $past(next_addr));

    // R10: the saved address changes only with a trap
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !trap_pulse |-> $stable(trap_addr));

    // R4: masks without outcome bits never trap
    p_never_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_mask[MASK_W-1:1] == '0) |=> !trap_pulse);

    // R5: all outcome bits set traps for every defined source
    p_always_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&cond_mask[MASK_W-1:1]) && src_sel != SRC_NONE) |=> trap_pulse);

    // R9: the reserved source never traps
    p_reserved_src_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_sel == SRC_NONE) |=> !trap_pulse);

    // R3: the comparator reports one of the three outcomes
    p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
        code != CC_BAD);
endmodule

// File: tb/cmp_trap_unit_tb.sv
module cmp_trap_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  src_sel = '0;
    logic        op_wide = 1'b0;
    logic        is_signed = 1'b0;
    logic [3:0]  cond_mask = '0;
    logic [63:0] reg_a = '0, reg_b = '0, mem_word = '0, next_addr = '0;
    logic [15:0] imm16 = '0;
    logic        trap_pulse;
    logic [63:0] trap_addr;
    logic [3:0]  exc_subcode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [63:0] held_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_trap_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel),
        .op_wide(op_wide), .is_signed(is_signed), .cond_mask(cond_mask),
        .reg_a(reg_a), .reg_b(reg_b), .imm16(imm16), .mem_word(mem_word),
        .next_addr(next_addr), .trap_pulse(trap_pulse), .trap_addr(trap_addr),
        .exc_subcode(exc_subcode)
    );

    function automatic logic [63:0] val_of(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h0000_0000_7FFF_FFFF;
            4: return 64'h0000_0000_8000_0000;
            5: return 64'hFFFF_FFFF_8000_0000;
            6: return 64'h1234_5678_0000_0001;
            default: return 64'hFFFF_FFFF_0000_0000;
        endcase
    endfunction

    function automatic logic [15:0] imm_of(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h8000;
            4: return 16'h7FFF;
            5: return 16'h0029;
            6: return 16'h0002;
            default: return 16'h1234;
        endcase
    endfunction

    // Expected trap decision computed from the requirements.
    function automatic logic model(input int src, input bit wide, input bit sgn,
                                   input logic [3:0] m, input logic [63:0] a,
                                   input logic [63:0] rb, input logic [15:0] im,
                                   input logic [63:0] mw);
        logic [63:0] b;
        int outcome;   // -1 low, 0 equal, +1 high
        if (src == 3) return 1'b0;
        if (src == 0) b = rb;
        else if (src == 2) b = mw;
        else if (sgn) b = 64'(signed'(im));
        else b = {48'd0, im};
        if (wide) begin
            if (sgn) outcome = ($signed(a) < $signed(b)) ? -1 : ($signed(a) > $signed(b)) ? 1 : 0;
            else     outcome = (a < b) ? -1 : (a > b) ? 1 : 0;
        end else begin
            logic [31:0] la, lb;
            la = a[31:0]; lb = b[31:0];
            if (sgn) outcome = ($signed(la) < $signed(lb)) ? -1 : ($signed(la) > $signed(lb)) ? 1 : 0;
            else     outcome = (la < lb) ? -1 : (la > lb) ? 1 : 0;
        end
        case (outcome)
            0:  return (m & 4'd8) != 0;
            -1: return (m & 4'd4) != 0;
            default: return (m & 4'd2) != 0;
        endcase
    endfunction

    function automatic string tag_of(input int src, input bit wide, input bit sgn,
                                     input logic [3:0] m);
        if (src == 3)            return "R9";
        if (m[3:1] == 3'b000)    return "R4";
        if (m[3:1] == 3'b111)    return "R5";
        if (src == 1)            return "R8";
        if (src == 2)            return "R9";
        if (!wide)               return "R7";
        if (sgn)                 return "R6";
        return "R3";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int vec;
        logic exp_t;
        string tg;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "trap_pulse in reset", {63'd0, trap_pulse}, 64'd0);
        check("R1", "trap_addr in reset", trap_addr, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "trap_pulse after reset", {63'd0, trap_pulse}, 64'd0);
        check("R1", "trap_addr after reset", trap_addr, 64'd0);

        // R2: idle cycle with an always-trap mask
        in_valid = 1'b0; cond_mask = 4'd14; src_sel = 2'd0; next_addr = 64'hDEAD;
        @(negedge clk);
        check("R2", "no trap when idle", {63'd0, trap_pulse}, 64'd0);
        check("R2", "addr untouched when idle", trap_addr, 64'd0);

        vec = 0;
        for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
        for (int g = 0; g < 2; g++)
        for (int m = 0; m < 16; m++)
        for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++) begin
            logic [63:0] bv;
            bv = val_of(bi);
            in_valid = 1'b1; src_sel = 2'(s); op_wide = w[0]; is_signed = g[0];
            cond_mask = 4'(m); reg_a = val_of(ai); reg_b = bv;
            imm16 = imm_of(bi); mem_word = {bv[31:0], bv[63:32]};
            next_addr = 64'h1000 + 64'(vec) * 6;
            exp_t = model(s, w[0], g[0], 4'(m), reg_a, reg_b, imm16, mem_word);
            tg = tag_of(s, w[0], g[0], 4'(m));
            if (exp_t) held_addr = next_addr;
            @(negedge clk);
            check(tg, "trap_pulse", {63'd0, trap_pulse}, {63'd0, exp_t});
            if (exp_t) begin
                check("R10", "trap_addr", trap_addr, held_addr);
                check("R10", "exc_subcode", {60'd0, exc_subcode}, 64'd0);
            end
            vec++;
        end

        // R2: pulse lasts one cycle and idle keeps the saved address (R10)
        in_valid = 1'b0; next_addr = 64'hBEEF;
        @(negedge clk);
        @(negedge clk);
        check("R2", "pulse ended after idle", {63'd0, trap_pulse}, 64'd0);
        check("R10", "address held across idle", trap_addr, held_addr);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule